// File: doc/BRIEF.md
# Assertion Stop and Status Collector

This block gathers the fire outputs of many fixed hardware assertion checkers and connects them to a scan-based run-stop debug setup. Each assertion belongs to a group, and a group is chosen at elaboration. A debug controller turns groups on or off through a small enable register. That register is loaded serially with a shift-then-update scheme.

Each assertion also carries an error or warning class. An enabled error raises a registered stop request towards the clock controller, so it works like a hardware breakpoint. A warning only records itself. Both kinds set their own bit in a holding status register. That bit stays set until a scan capture takes a snapshot of the register, so a one-cycle pulse is never lost.

The snapshot is then shifted out serially, one bit per assertion, least significant first. A clear command wipes the recorded status and drops the stop request.

Top module: `asc_top`

## Requirements
- R1: A fire from an assertion whose group enable is 0 sets no status bit and does not raise the stop request. The group of assertion i comes from the elaboration map, which by default is i modulo the group count.
- R2: An enabled fire whose class input is 1 (error) makes the stop request high on the clock edge after the fire.
- R3: An enabled fire whose class input is 0 (warning) leaves the stop request low and sets the status bit of that assertion.
- R4: A status bit that has been set stays set, however many idle cycles pass, until a status capture or a clear.
- R5: Repeated fires of one assertion before a capture leave a single set bit. The next capture after the read-out returns that bit as 0.
- R6: A status capture (capture high while select is 0) copies the held status into the read-out chain and empties the holding register. A fire in the capture cycle is kept in the holding register for the next capture.
- R7: With select at 0, the serial output shows status bit 0 right after the capture. Each shift cycle then moves to the next higher bit.
- R8: With select at 1, shifting loads the enable chain and the first bit shifted in lands on group 0. An update cycle copies the chain into the enables. A capture loads the current enables into the chain for read-back, with group 0 on the serial output first.
- R9: A clear empties the status register and drops the stop request on the next edge. Fires in the clear cycle still set their status bits, and an error fire in that cycle keeps the stop request high.
- R10: Once high, the stop request stays high across captures and shifts until a clear.
- R11: After reset the stop request is low, all status bits are 0 and every group is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fire | input | NUM_ASSERT | Fire pulse from each assertion checker |
| errClass | input | NUM_ASSERT | Per-assertion class: 1 error, 0 warning |
| scanSel | input | 1 | Chain select: 0 status, 1 group enables |
| scanCapture | input | 1 | Parallel load into the selected chain |
| scanShift | input | 1 | Shift the selected chain one bit toward the output |
| scanUpdate | input | 1 | Copy the enable chain into the enables (select 1) |
| scanIn | input | 1 | Serial data into the selected chain's top bit |
| statusClear | input | 1 | Clear status bits and stop request |
| scanOut | output | 1 | Serial data from bit 0 of the selected chain |
| stopReq | output | 1 | Registered stop request |

## Verification
The bench builds the block with twelve assertions in three groups, using the default round-robin map. With these values every group holds four assertions, so disabling one group visibly masks the bits 2, 5, 8 and 11. A whole status read-out also takes only a dozen shift cycles, which leaves room for many capture, clear and enable-rewrite rounds within the random phase. The three-bit enable chain keeps full read-back and rewrites of the enables cheap enough to mix into random traffic.

// File: rtl/asc_pkg.sv
package asc_pkg;

  localparam int MAP_SLOTS = 256;
  localparam int MAP_W     = 8;

  typedef struct packed {
    logic captStat;
    logic captCtrl;
    logic shiftStat;
    logic shiftCtrl;
    logic updCtrl;
    logic clear;
  } ascStrobe_t;

  // Default group map: assertion i belongs to group i % groups.
  function automatic logic [MAP_SLOTS*MAP_W-1:0] roundRobinMap(int groups);
    logic [MAP_SLOTS*MAP_W-1:0] m;
    m = '0;
    for (int i = 0; i < MAP_SLOTS; i++) begin
      m[i*MAP_W +: MAP_W] = MAP_W'(i % groups);
    end
    return m;
  endfunction

endpackage

// File: rtl/asc_group_expand.sv
module asc_group_expand
  import asc_pkg::*;
#(
  parameter int NUM_ASSERT = 16,
  parameter int NUM_GROUPS = 4,
  parameter logic [MAP_SLOTS*MAP_W-1:0] GROUP_MAP = roundRobinMap(NUM_GROUPS)
) (
  input  logic [NUM_GROUPS-1:0] grpEn,
  output logic [NUM_ASSERT-1:0] enMask
);

  // One enable per assertion, picked from its fixed group.
  for (genvar i = 0; i < NUM_ASSERT; i++) begin : g_map
    localparam int GI = int'(GROUP_MAP[i*MAP_W +: MAP_W]);
    if (GI < NUM_GROUPS) begin : g_valid
      assign enMask[i] = grpEn[GI];
    end else begin : g_none
      assign enMask[i] = 1'b0;
    end
  end

endmodule

// File: rtl/asc_ctrl.sv
module asc_ctrl
  import asc_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  scanSel,
  input  logic                  scanCapture,
  input  logic                  scanShift,
  input  logic                  scanUpdate,
  input  logic                  scanIn,
  input  logic                  statusClear,
  output ascStrobe_t            strobe,
  output logic [NUM_GROUPS-1:0] grpEn,
  output logic                  ctrlOut
);

  logic [NUM_GROUPS-1:0] ctrlChain;
  logic [NUM_GROUPS-1:0] inMsb;

  // Capture has priority over shift, shift over update.
  always_comb begin
    strobe.captStat  = scanCapture & ~scanSel;
    strobe.captCtrl  = scanCapture &  scanSel;
    strobe.shiftStat = scanShift & ~scanCapture & ~scanSel;
    strobe.shiftCtrl = scanShift & ~scanCapture &  scanSel;
    strobe.updCtrl   = scanUpdate & ~scanShift & ~scanCapture & scanSel;
    strobe.clear     = statusClear;
  end

  always_comb begin
    inMsb = '0;
    inMsb[NUM_GROUPS-1] = scanIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlChain <= '0;
    end else if (strobe.captCtrl) begin
      ctrlChain <= grpEn;
    end else if (strobe.shiftCtrl) begin
      ctrlChain <= (ctrlChain >> 1) | inMsb;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpEn <= '1;
    end else if (strobe.updCtrl) begin
      grpEn <= ctrlChain;
    end
  end

  assign ctrlOut = ctrlChain[0];

  // R8: enables move only on an update cycle
  p_en_only_on_update_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(scanUpdate && scanSel) |=> $stable(grpEn));

  // R8: a shift without update leaves the applied enables alone
  p_shift_keeps_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    (scanShift && scanSel) |=> $stable(grpEn));

endmodule

// File: rtl/asc_datapath.sv
module asc_datapath
  import asc_pkg::*;
#(
  parameter int NUM_ASSERT = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ascStrobe_t            strobe,
  input  logic [NUM_ASSERT-1:0] fireEn,
  input  logic [NUM_ASSERT-1:0] errFire,
  input  logic                  scanIn,
  output logic                  statOut,
  output logic                  stopReq
);

  logic [NUM_ASSERT-1:0] statusHold;
  logic [NUM_ASSERT-1:0] statShift;
  logic [NUM_ASSERT-1:0] inMsb;
  logic                  anyErr;

  assign anyErr = |errFire;

  always_comb begin
    inMsb = '0;
    inMsb[NUM_ASSERT-1] = scanIn;
  end

  // Sticky status: new fires always win over clear or capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusHold <= '0;
    end else if (strobe.clear || strobe.captStat) begin
      statusHold <= fireEn;
    end else begin
      statusHold <= statusHold | fireEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopReq <= 1'b0;
    end else if (strobe.clear) begin
      stopReq <= anyErr;
    end else if (anyErr) begin
      stopReq <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statShift <= '0;
    end else if (strobe.captStat) begin
      statShift <= statusHold;
    end else if (strobe.shiftStat) begin
      statShift <= (statShift >> 1) | inMsb;
    end
  end

  assign statOut = statShift[0];

  // R1: a status bit only rises where an enabled fire was seen
  p_rise_needs_fire_r1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusHold & ~$past(statusHold) & ~$past(fireEn)) == '0));

  // R2: an enabled error fire raises the stop request
  p_error_stops_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|errFire) |=> stopReq);

  // R3: without an error fire, a low stop request stays low
  p_warn_no_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stopReq && !(|errFire)) |=> !stopReq);

  // R4: bits are kept while neither capture nor clear happens
  p_status_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.captStat && !strobe.clear)
      |=> ((statusHold & $past(statusHold)) == $past(statusHold)));

  // R9: clear without an error fire drops the stop request
  p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clear && !(|errFire)) |=> !stopReq);

  // R10: the stop request holds until a clear
  p_stop_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !strobe.clear) |=> stopReq);

endmodule

// File: rtl/asc_top.sv
module asc_top
  import asc_pkg::*;
#(
  parameter int NUM_ASSERT = 16,
  parameter int NUM_GROUPS = 4,
  parameter logic [MAP_SLOTS*MAP_W-1:0] GROUP_MAP = roundRobinMap(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_ASSERT-1:0] fire,
  input  logic [NUM_ASSERT-1:0] errClass,
  input  logic                  scanSel,
  input  logic                  scanCapture,
  input  logic                  scanShift,
  input  logic                  scanUpdate,
  input  logic                  scanIn,
  input  logic                  statusClear,
  output logic                  scanOut,
  output logic                  stopReq
);

  ascStrobe_t            strobe;
  logic [NUM_GROUPS-1:0] grpEn;
  logic [NUM_ASSERT-1:0] enMask;
  logic [NUM_ASSERT-1:0] fireEn;
  logic [NUM_ASSERT-1:0] errFire;
  logic                  ctrlOut;
  logic                  statOut;

  asc_ctrl #(.NUM_GROUPS(NUM_GROUPS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .scanSel     (scanSel),
    .scanCapture (scanCapture),
    .scanShift   (scanShift),
    .scanUpdate  (scanUpdate),
    .scanIn      (scanIn),
    .statusClear (statusClear),
    .strobe      (strobe),
    .grpEn       (grpEn),
    .ctrlOut     (ctrlOut)
  );

  asc_group_expand #(
    .NUM_ASSERT (NUM_ASSERT),
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_MAP  (GROUP_MAP)
  ) u_expand (
    .grpEn  (grpEn),
    .enMask (enMask)
  );

  assign fireEn  = fire & enMask;
  assign errFire = fireEn & errClass;

  asc_datapath #(.NUM_ASSERT(NUM_ASSERT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .fireEn  (fireEn),
    .errFire (errFire),
    .scanIn  (scanIn),
    .statOut (statOut),
    .stopReq (stopReq)
  );

  assign scanOut = scanSel ? ctrlOut : statOut;

endmodule

// File: tb/asc_top_tb.sv
`timescale 1ns/1ps
module asc_top_tb;

  localparam int N = 12;
  localparam int G = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] fire = '0;
  logic [N-1:0] errClass = '0;
  logic scanSel = 1'b0, scanCapture = 1'b0, scanShift = 1'b0;
  logic scanUpdate = 1'b0, scanIn = 1'b0, statusClear = 1'b0;
  logic scanOut, stopReq;

  always #2.5 clk = ~clk;

  asc_top #(.NUM_ASSERT(N), .NUM_GROUPS(G)) u_dut (
    .clk(clk), .rstN(rstN), .fire(fire), .errClass(errClass),
    .scanSel(scanSel), .scanCapture(scanCapture), .scanShift(scanShift),
    .scanUpdate(scanUpdate), .scanIn(scanIn), .statusClear(statusClear),
    .scanOut(scanOut), .stopReq(stopReq)
  );

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  logic [N-1:0] mStat;
  logic         mStop;
  logic [G-1:0] mEn;

  function automatic logic [N-1:0] maskOf(logic [G-1:0] en);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = en[i % G];
    return m;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: model update at the edge, stop request compared at negedge.
  task automatic step(string req = "R10");
    logic [N-1:0] fe;
    logic anyE;
    @(posedge clk);
    fe   = fire & maskOf(mEn);
    anyE = |(fe & errClass);
    if (statusClear) begin
      mStat = fe; mStop = anyE;
    end else if (scanCapture && !scanSel) begin
      mStat = fe; mStop = mStop | anyE;
    end else begin
      mStat = mStat | fe; mStop = mStop | anyE;
    end
    @(negedge clk);
    chk(req, 32'(stopReq), 32'(mStop));
    fire = '0; statusClear = 1'b0; scanCapture = 1'b0;
    scanShift = 1'b0; scanUpdate = 1'b0;
  endtask

  // Capture and shift out the status; capFire is driven in the capture cycle.
  task automatic readStatus(string req, logic [N-1:0] capFire, output logic [N-1:0] got);
    logic [N-1:0] exp;
    exp = mStat;
    scanSel = 1'b0; scanCapture = 1'b1; fire = capFire;
    step(req);
    got[0] = scanOut;
    for (int j = 1; j < N; j++) begin
      scanShift = 1'b1; scanIn = 1'b0;
      step(req);
      got[j] = scanOut;
    end
    chk(req, 32'(got), 32'(exp));
  endtask

  task automatic readCtrl(string req, logic [G-1:0] exp);
    logic [G-1:0] got;
    scanSel = 1'b1; scanCapture = 1'b1;
    step(req);
    got[0] = scanOut;
    for (int j = 1; j < G; j++) begin
      scanShift = 1'b1;
      step(req);
      got[j] = scanOut;
    end
    scanSel = 1'b0;
    chk(req, 32'(got), 32'(exp));
  endtask

  task automatic writeEn(logic [G-1:0] en);
    scanSel = 1'b1;
    for (int k = 0; k < G; k++) begin
      scanShift = 1'b1; scanIn = en[k];
      step("R8");
    end
    scanUpdate = 1'b1;
    step("R8");
    mEn = en;
    scanSel = 1'b0; scanIn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] got;
    void'($urandom(32'd20240611));
    mStat = '0; mStop = 1'b0; mEn = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset state
    chk("R11 stop", 32'(stopReq), 32'd0);
    readStatus("R11", '0, got);
    readCtrl("R11 R8 enables", 3'b111);

    // R3: warning records but does not stop
    fire = 12'h002; errClass = '0;
    step("R3");
    readStatus("R3 R7", '0, got);

    // R4: single pulse survives idle cycles
    fire = 12'h040;
    step("R4");
    repeat (6) step("R4");
    readStatus("R4", '0, got);

    // R5: repeated fires leave one bit, gone after read
    for (int r = 0; r < 3; r++) begin fire = 12'h008; step("R5"); end
    readStatus("R5", '0, got);
    readStatus("R5 second", '0, got);

    // R2, R10, R9: error stop, hold through capture, clear
    errClass = 12'h010; fire = 12'h010;
    step("R2");
    chk("R2 stop", 32'(stopReq), 32'd1);
    readStatus("R10", '0, got);
    chk("R10 stop after capture", 32'(stopReq), 32'd1);
    statusClear = 1'b1;
    step("R9");
    chk("R9 stop cleared", 32'(stopReq), 32'd0);

    // R6: fire in capture cycle held for next capture
    fire = 12'h001; errClass = '0;
    step("R6");
    readStatus("R6", 12'h004, got);
    readStatus("R6 next", '0, got);

    // R9: clear loses old bits but keeps a same-cycle fire
    fire = 12'h0A0; step("R9");
    statusClear = 1'b1; fire = 12'h100;
    step("R9");
    readStatus("R9 fire wins", '0, got);
    errClass = 12'h800; statusClear = 1'b1; fire = 12'h800;
    step("R9");
    chk("R9 error in clear", 32'(stopReq), 32'd1);
    statusClear = 1'b1; errClass = '0;
    step("R9");

    // R1, R8: disable group 2, fire everything as errors
    writeEn(3'b011);
    readCtrl("R8 readback", 3'b011);
    errClass = 12'h924; fire = '1;
    step("R1");
    chk("R1 no stop", 32'(stopReq), 32'd0);
    readStatus("R1 masked", '0, got);
    chk("R1 bits", 32'(got), 32'h6DB);
    writeEn(3'b111);

    // Random phase
    for (int c = 0; c < 1500; c++) begin
      if ($urandom % 3 == 0) fire = N'(1) << ($urandom % N);
      errClass = N'($urandom) & N'($urandom) & N'($urandom);
      if ($urandom % 40 == 0) statusClear = 1'b1;
      step("R2 R10 random");
      if (c % 37 == 36) readStatus("R6 R7 random", N'($urandom) & 12'h111, got);
      if (c % 211 == 210) begin
        writeEn(G'($urandom));
        readCtrl("R8 random", mEn);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule